// File: doc/BRIEF.md
# LED Matrix Open/Short Fault Capture

This block records, for every row and column position of a scanned LED matrix, whether that LED showed a fault during a detection run. Software writes a two-bit request code. A change of that code from zero to a non-zero value arms one run. The run waits for the next scan frame to begin. It then samples the analog comparator of each lit column at the end of every row slot for two complete frames.

At the end of the last row slot of the second frame, the accumulated flags are written into a bank of read-only status bytes and a done flag is raised. A position whose scaling byte is zero is left out of the update and keeps its old flag.

The scan engine supplies the current row index and a one-cycle strobe near the end of each row's on-time. The analog front end supplies one open-comparator and one short-comparator bit per column. Holding the current limit and disabling the de-ghost resistors during a run are the caller's duty and are not checked here.

Top module: `osd_capture`

## Requirements
- R1: Request code 01 or 11 selects open detection and takes flags from `open_i`. Code 10 selects short detection and takes flags from `short_i`. The comparator that is not selected has no effect on the result.
- R2: A run is armed only when `mode_i` changes from 00 to a non-zero code. A change between two non-zero codes starts nothing. A second run needs 00 and then a request code.
- R3: Sampling begins at the first row-0 strobe after the trigger; strobes before it are ignored. The status bytes and `done_o` update on the clock edge of the last-row strobe of the second full frame. They are visible from the next cycle, and not earlier.
- R4: A position is flagged when its comparator was high in either of the two sampled frames.
- R5: Status byte b sits at `stat_o[8*b +: 8]`, with b = row*3 + group. Bit k of that byte holds column group*6+k. Columns are zero-based, so group 0 holds columns 0–5. Bits 7:6 always read 0.
- R6: A position whose scaling byte is zero at the completing edge keeps its previous flag.
- R7: After reset all status bytes are 0x00 and `done_o` is 0.
- R8: A trigger clears `done_o`. The status bytes change only on the edge where `done_o` rises.
- R9: A new trigger during a run restarts it: flags gathered before the restart are discarded.
- R10: Row strobes while no run is armed leave the status bytes and `done_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Detect request code: 00 off, 01/11 open, 10 short |
| row_i | input | 2 | Row index of the current scan slot |
| slot_end_i | input | 1 | One-cycle strobe near the end of the row on-time |
| open_i | input | 18 | Open comparator result, one bit per column |
| short_i | input | 18 | Short comparator result, one bit per column |
| scale_i | input | 576 | Scaling bytes, position row*18+col at bits 8*pos +: 8 |
| stat_o | output | 96 | Twelve status bytes |
| done_o | output | 1 | Last run completed |

## Verification
The bench builds the block with its defaults: four rows, eighteen columns, six-column groups and two capture frames. With these values every row, every group byte and both padding bits appear in the twelve checked bytes. The two-frame OR and the wait for a frame start can each be reached within a few dozen strobes. Random runs mix open and short requests, random zero scaling bytes and a fault pattern that changes every frame. Directed runs cover a trigger in the middle of a frame, a restart in the middle of a run, a change between two non-zero codes, and a single fault placed in one frame only.

// File: rtl/osd_pkg.sv
package osd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } osd_state_e;

  typedef enum logic {
    KIND_OPEN  = 1'b0,
    KIND_SHORT = 1'b1
  } osd_kind_e;

  localparam logic [1:0] MODE_OFF   = 2'b00;
  localparam logic [1:0] MODE_SHORT = 2'b10;

  function automatic osd_kind_e decode_kind(input logic [1:0] mode);
    return (mode == MODE_SHORT) ? KIND_SHORT : KIND_OPEN;
  endfunction

endpackage

// File: rtl/osd_trigger.sv
module osd_trigger
  import osd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic [1:0] mode_i,
  output logic      trig_o,
  output osd_kind_e kind_o
);

  logic [1:0] mode_q;

  // fires only on leaving the off code
  assign trig_o = (mode_q == MODE_OFF) && (mode_i != MODE_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      kind_o <= KIND_OPEN;
    end else begin
      mode_q <= mode_i;
      if (trig_o) kind_o <= decode_kind(mode_i);
    end
  end

endmodule

// File: rtl/osd_sequencer.sv
module osd_sequencer
  import osd_pkg::*;
#(
  parameter int NUM_ROWS   = 4,
  parameter int NUM_FRAMES = 2,
  parameter int ROW_W      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             slot_end_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             sample_o,
  output logic             commit_o,
  output logic             done_o
);

  localparam int FRM_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(NUM_ROWS - 1);
  localparam logic [FRM_W-1:0] LAST_FRM  = FRM_W'(NUM_FRAMES - 1);

  osd_state_e       state_q;
  logic [FRM_W-1:0] frm_q;
  logic             row_ok;
  logic             frame_end;

  assign row_ok    = {1'b0, row_i} < (ROW_W+1)'(NUM_ROWS);
  assign sample_o  = slot_end_i && !trig_i && row_ok &&
                     ((state_q == ST_RUN) ||
                      ((state_q == ST_WAIT) && (row_i == '0)));
  assign frame_end = sample_o && (row_i == LAST_ROW);
  assign commit_o  = frame_end && (frm_q == LAST_FRM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      frm_q   <= '0;
      done_o  <= 1'b0;
    end else if (trig_i) begin
      state_q <= ST_WAIT;
      frm_q   <= '0;
      done_o  <= 1'b0;
    end else if (commit_o) begin
      state_q <= ST_IDLE;
      frm_q   <= '0;
      done_o  <= 1'b1;
    end else if (frame_end) begin
      state_q <= ST_RUN;
      frm_q   <= frm_q + 1'b1;
    end else if (sample_o) begin
      state_q <= ST_RUN;
    end
  end

endmodule

// File: rtl/osd_flag_bank.sv
module osd_flag_bank #(
  parameter int NUM_ROWS  = 4,
  parameter int NUM_COLS  = 18,
  parameter int GROUP_W   = 6,
  parameter int ROW_W     = 2,
  parameter int NUM_BYTES = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       sample_i,
  input  logic                       commit_i,
  input  logic [ROW_W-1:0]           row_i,
  input  logic [NUM_COLS-1:0]        fault_i,
  input  logic [NUM_ROWS*NUM_COLS*8-1:0] scale_i,
  output logic [NUM_BYTES*8-1:0]     stat_o
);

  localparam int GRP_PER_ROW = NUM_COLS / GROUP_W;

  logic [NUM_COLS-1:0] acc_q  [NUM_ROWS];
  logic [NUM_COLS-1:0] flag_q [NUM_ROWS];

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic                hit;
    logic [NUM_COLS-1:0] acc_nxt;

    assign hit     = sample_i && (row_i == ROW_W'(r));
    // commit sees this slot's sample as well
    assign acc_nxt = acc_q[r] | (hit ? fault_i : '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       acc_q[r] <= '0;
      else if (clear_i)  acc_q[r] <= '0;
      else if (commit_i) acc_q[r] <= '0;
      else if (hit)      acc_q[r] <= acc_nxt;
    end

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      logic lit;
      assign lit = |scale_i[(r*NUM_COLS+c)*8 +: 8];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                flag_q[r][c] <= 1'b0;
        else if (commit_i && lit)   flag_q[r][c] <= acc_nxt[c];
      end
    end

    for (genvar g = 0; g < GRP_PER_ROW; g++) begin : g_grp
      localparam int B = r*GRP_PER_ROW + g;
      assign stat_o[B*8 +: GROUP_W] = flag_q[r][g*GROUP_W +: GROUP_W];
      if (GROUP_W < 8) begin : g_pad
        assign stat_o[B*8+GROUP_W +: 8-GROUP_W] = '0;
      end
    end
  end

endmodule

// File: rtl/osd_capture.sv
module osd_capture
  import osd_pkg::*;
#(
  parameter int NUM_ROWS   = 4,
  parameter int NUM_COLS   = 18,
  parameter int GROUP_W    = 6,
  parameter int NUM_FRAMES = 2,
  localparam int ROW_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int NUM_BYTES = NUM_ROWS * (NUM_COLS / GROUP_W)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [1:0]                     mode_i,
  input  logic [ROW_W-1:0]               row_i,
  input  logic                           slot_end_i,
  input  logic [NUM_COLS-1:0]            open_i,
  input  logic [NUM_COLS-1:0]            short_i,
  input  logic [NUM_ROWS*NUM_COLS*8-1:0] scale_i,
  output logic [NUM_BYTES*8-1:0]         stat_o,
  output logic                           done_o
);

  logic                trig;
  osd_kind_e           kind;
  logic                sample;
  logic                commit;
  logic [NUM_COLS-1:0] fault;

  assign fault = (kind == KIND_SHORT) ? short_i : open_i;

  osd_trigger u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .trig_o (trig),
    .kind_o (kind)
  );

  osd_sequencer #(
    .NUM_ROWS   (NUM_ROWS),
    .NUM_FRAMES (NUM_FRAMES),
    .ROW_W      (ROW_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .slot_end_i (slot_end_i),
    .row_i      (row_i),
    .sample_o   (sample),
    .commit_o   (commit),
    .done_o     (done_o)
  );

  osd_flag_bank #(
    .NUM_ROWS  (NUM_ROWS),
    .NUM_COLS  (NUM_COLS),
    .GROUP_W   (GROUP_W),
    .ROW_W     (ROW_W),
    .NUM_BYTES (NUM_BYTES)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (trig),
    .sample_i (sample),
    .commit_i (commit),
    .row_i    (row_i),
    .fault_i  (fault),
    .scale_i  (scale_i),
    .stat_o   (stat_o)
  );

endmodule

// File: rtl/osd_capture_chk.sv
module osd_capture_chk #(
  parameter int NUM_ROWS   = 4,
  parameter int NUM_COLS   = 18,
  parameter int GROUP_W    = 6,
  parameter int NUM_FRAMES = 2,
  parameter int ROW_W      = 2,
  parameter int NUM_BYTES  = 12
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [1:0]                     mode_i,
  input logic [ROW_W-1:0]               row_i,
  input logic                           slot_end_i,
  input logic [NUM_ROWS*NUM_COLS*8-1:0] scale_i,
  input logic [NUM_BYTES*8-1:0]         stat_o,
  input logic                           done_o
);

  localparam int LAST_POS = NUM_ROWS*NUM_COLS - 1;
  localparam int LAST_BIT = (NUM_BYTES-1)*8 + ((NUM_COLS-1) % GROUP_W);

  logic [1:0] mode_q;
  logic [3:0] frames_q;
  logic       trig;
  logic       pad_or;

  assign trig = (mode_q == 2'b00) && (mode_i != 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 2'b00;
      frames_q <= '0;
    end else begin
      mode_q <= mode_i;
      if (trig) frames_q <= '0;
      else if (slot_end_i && row_i == ROW_W'(NUM_ROWS-1) && frames_q != 4'hf)
        frames_q <= frames_q + 1'b1;
    end
  end

  always_comb begin
    pad_or = 1'b0;
    for (int b = 0; b < NUM_BYTES; b++)
      for (int k = GROUP_W; k < 8; k++)
        pad_or = pad_or | stat_o[b*8+k];
  end

  p_pad_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_or);

  p_two_frames_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (frames_q >= 4'(NUM_FRAMES)));

  p_trig_clears_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> !done_o);

  p_stat_moves_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stat_o) |-> $rose(done_o));

  p_no_retrigger_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !trig) |=> done_o);

  p_zero_scale_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scale_i[7:0] == 8'h00) |=> (stat_o[0] == $past(stat_o[0])));

  p_zero_scale_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scale_i[LAST_POS*8 +: 8] == 8'h00) |=> (stat_o[LAST_BIT] == $past(stat_o[LAST_BIT])));

endmodule

bind osd_capture osd_capture_chk #(
  .NUM_ROWS   (NUM_ROWS),
  .NUM_COLS   (NUM_COLS),
  .GROUP_W    (GROUP_W),
  .NUM_FRAMES (NUM_FRAMES),
  .ROW_W      (ROW_W),
  .NUM_BYTES  (NUM_BYTES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .row_i      (row_i),
  .slot_end_i (slot_end_i),
  .scale_i    (scale_i),
  .stat_o     (stat_o),
  .done_o     (done_o)
);

// File: tb/osd_capture_tb_top.sv
module osd_capture_tb_top;

  localparam int ROWS   = 4;
  localparam int COLS   = 18;
  localparam int GRP    = 6;
  localparam int FRAMES = 2;
  localparam int NPOS   = ROWS*COLS;
  localparam int NBYTES = ROWS*(COLS/GRP);

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [1:0]          mode_i = 2'b00;
  logic [1:0]          row_i = '0;
  logic                slot_end_i = 1'b0;
  logic [COLS-1:0]     open_i = '0;
  logic [COLS-1:0]     short_i = '0;
  logic [NPOS*8-1:0]   scale_i;
  logic [NBYTES*8-1:0] stat_o;
  logic                done_o;

  always #10 clk_i = ~clk_i;

  osd_capture dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .row_i(row_i),
    .slot_end_i(slot_end_i), .open_i(open_i), .short_i(short_i),
    .scale_i(scale_i), .stat_o(stat_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0]      sc [NPOS];
  logic [COLS-1:0] fo [ROWS];
  logic [COLS-1:0] fs [ROWS];
  logic            exp_flag [NPOS];
  logic            m_acc [NPOS];
  logic            exp_done = 1'b0;
  int              m_state = 0;
  int              m_frame = 0;
  bit              m_short = 1'b0;
  logic [1:0]      m_mode = 2'b00;

  always_comb for (int p = 0; p < NPOS; p++) scale_i[p*8 +: 8] = sc[p];

  function automatic logic [7:0] exp_byte(input int b);
    logic [7:0] v = 8'h00;
    int r = b / (COLS/GRP);
    int g = b % (COLS/GRP);
    for (int k = 0; k < GRP; k++) v[k] = exp_flag[r*COLS + g*GRP + k];
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [NBYTES*8-1:0] e;
    for (int b = 0; b < NBYTES; b++) e[b*8 +: 8] = exp_byte(b);
    checks++;
    if (stat_o !== e) begin
      errors++;
      $display("FAIL %s stat actual=%h expected=%h", req, stat_o, e);
    end
    chk({req, " done"}, 64'(done_o), 64'(exp_done));
  endtask

  task automatic set_mode(input logic [1:0] v);
    @(negedge clk_i);
    if (m_mode == 2'b00 && v != 2'b00) begin
      m_state = 1; m_frame = 0; exp_done = 1'b0; m_short = (v == 2'b10);
      for (int p = 0; p < NPOS; p++) m_acc[p] = 1'b0;
    end
    m_mode = v;
    mode_i = v;
  endtask

  task automatic slot(input int r);
    bit smp;
    @(negedge clk_i);
    row_i = 2'(r); open_i = fo[r]; short_i = fs[r]; slot_end_i = 1'b1;
    smp = (m_state == 2) || (m_state == 1 && r == 0);
    if (smp) begin
      m_state = 2;
      for (int c = 0; c < COLS; c++)
        m_acc[r*COLS+c] = m_acc[r*COLS+c] | (m_short ? fs[r][c] : fo[r][c]);
      if (r == ROWS-1) begin
        if (m_frame == FRAMES-1) begin
          for (int p = 0; p < NPOS; p++) if (sc[p] != 0) exp_flag[p] = m_acc[p];
          exp_done = 1'b1; m_state = 0;
        end else m_frame++;
      end
    end
    @(negedge clk_i);
    slot_end_i = 1'b0;
  endtask

  task automatic rand_faults();
    for (int r = 0; r < ROWS; r++) begin
      fo[r] = COLS'($urandom) & COLS'($urandom);
      fs[r] = COLS'($urandom) & COLS'($urandom);
    end
  endtask

  task automatic clear_faults();
    for (int r = 0; r < ROWS; r++) begin fo[r] = '0; fs[r] = '0; end
  endtask

  task automatic frame();
    for (int r = 0; r < ROWS; r++) slot(r);
  endtask

  task automatic rand_frame();
    rand_faults();
    frame();
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < NPOS; p++) begin sc[p] = 8'h80; exp_flag[p] = 1'b0; m_acc[p] = 1'b0; end
    clear_faults();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R7 reset");

    // R10: strobes with no armed run
    rand_faults(); frame(); frame();
    check_all("R10 idle strobes");

    // R5 / R4: single faults in separate frames, all lit
    set_mode(2'b00);
    set_mode(2'b01);
    clear_faults(); fo[1][6] = 1'b1; frame();
    check_all("R3 one frame not done");
    clear_faults(); fo[2][17] = 1'b1; frame();
    chk("R5 byte4", 64'(stat_o[4*8 +: 8]), 64'h01);
    chk("R5 byte8", 64'(stat_o[8*8 +: 8]), 64'h20);
    check_all("R4 or of two frames");

    // R2: non-zero to non-zero change starts nothing
    set_mode(2'b10);
    rand_frame(); rand_frame(); rand_frame();
    check_all("R2 no retrigger");

    // R1: short run, open input random but unused
    set_mode(2'b00); set_mode(2'b10);
    rand_frame(); rand_frame();
    check_all("R1 short run");

    // R1: code 11 is open
    set_mode(2'b00); set_mode(2'b11);
    rand_frame(); rand_frame();
    check_all("R1 code 11 open");

    // R6: zero scaling keeps flags
    for (int p = 0; p < NPOS; p++) sc[p] = (p % 3 == 0) ? 8'h00 : 8'(p + 1);
    set_mode(2'b00); set_mode(2'b01);
    for (int r = 0; r < ROWS; r++) begin fo[r] = ~fo[r]; fs[r] = '0; end
    frame(); frame();
    check_all("R6 zero scaling held");
    for (int p = 0; p < NPOS; p++) sc[p] = 8'h01;

    // R3: trigger mid-frame, rows before row 0 not sampled
    set_mode(2'b00); set_mode(2'b01);
    clear_faults(); fo[2] = '1; fo[3] = '1;
    slot(2); slot(3);
    clear_faults(); frame();
    check_all("R3 mid frame wait");
    frame();
    check_all("R3 partial frame ignored");

    // R9: restart mid-run discards earlier samples
    set_mode(2'b00); set_mode(2'b01);
    clear_faults(); fo[0] = '1; frame();
    set_mode(2'b00); set_mode(2'b01);
    clear_faults(); frame(); frame();
    check_all("R9 restart");

    // random runs
    for (int i = 0; i < 30; i++) begin
      for (int p = 0; p < NPOS; p++) sc[p] = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
      set_mode(2'b00);
      set_mode(2'($urandom % 3 + 1));
      if ($urandom % 2 == 1) begin rand_faults(); slot(1 + $urandom % 3); end
      rand_frame();
      check_all("R3 random mid");
      rand_frame();
      check_all("R4 random run");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule